// File: doc/BRIEF.md
# Unaligned Access Bus Splitter

This block turns one processor-side access of one, two or four bytes at any byte address into one or two dword-aligned cycles on a 32-bit host bus with byte enables. Each bus cycle uses the request address with its two low bits cleared. When the bytes of the access fit inside one dword, the block issues a single cycle. When they cross a dword boundary, it issues two cycles. The first goes to the aligned address and the second to the next dword. Each cycle carries the byte-enable mask of the lanes it covers.

For writes, the block moves the request data onto the correct byte lanes. For reads, it gathers the returned lanes from one or both cycles into a right-justified result. A cycle that no target claims reads as all-ones lanes. A byte write to a reserved I/O port never reaches the bus. It comes out on a debug character strobe.

The requester uses a valid/ready handshake and receives a one-cycle done pulse, which carries the read result. On the bus side, address, enables, data and cycle type stay in place until the target acknowledges.

Top module: `unaligned_access_splitter`

## Requirements
- R1: `reqReady` is high only while the block is idle. A request is taken on a clock edge where `reqValid` and `reqReady` are both high. No further request is taken, and `reqReady` stays low, until its done pulse has been given.
- R2: Size code 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes. Let the offset be the low two address bits. Every bus cycle address has its two low bits at zero. An access whose offset plus byte count is at most 4 uses exactly one cycle, at the aligned address, with enable mask ((1 << bytes) - 1) << offset (bit k enables lane k = data bits 8k+7..8k).
- R3: An access whose offset plus byte count exceeds 4 uses exactly two cycles. The first is at the aligned address with the low four bits of the 8-bit mask ((1 << bytes) - 1) << offset. The second is at the aligned address + 4 with the high four bits of that mask. The second begins only after the first is acknowledged.
- R4: For writes, the first cycle carries the write data shifted left by 8 x offset, and the second carries it shifted right by 8 x (4 - offset). A target that stores the enabled lanes therefore ends up holding the request bytes at address, address+1, and so on, in little-endian order.
- R5: For reads, byte k of the result (k below the byte count) is the byte seen on the bus at address + k. Result bytes at or above the byte count are zero.
- R6: A cycle acknowledged with `busClaimed` low contributes 0xFF on every lane, whatever `busRdata` carries.
- R7: `busType` is 2'b00 for an I/O read, 2'b01 for an I/O write, 2'b10 for a memory read and 2'b11 for a memory write.
- R8: While `busValid` is high and `busAck` is low, `busValid`, `busAddr`, `busBe`, `busWdata` and `busType` hold their values into the next cycle.
- R9: `doneValid` is high for exactly one cycle per request, the cycle after the final acknowledge. `doneRdata` is valid in that cycle for reads.
- R10: An I/O byte write to address DEBUG_PORT (default 16'hFFFF) issues no bus cycle. Instead, in the cycle after acceptance, `dbgValid` and `doneValid` pulse together with `dbgChar` equal to the low data byte. The same address used as memory, or as a read, goes onto the bus as usual.
- R11: After reset, `reqReady` is high and `busValid`, `doneValid` and `dbgValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle and able to take a request |
| reqAddr | input | ADDR_W | Byte address of the access |
| reqSize | input | 2 | Size code: 0 byte, 1 two bytes, 2/3 four bytes |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqIo | input | 1 | 1 for I/O space, 0 for memory space |
| reqWdata | input | 32 | Right-justified write data |
| doneValid | output | 1 | One-cycle completion pulse |
| doneRdata | output | 32 | Right-justified read result |
| busValid | output | 1 | Bus cycle in progress |
| busType | output | 2 | Cycle type code |
| busAddr | output | ADDR_W | Dword-aligned bus address |
| busBe | output | 4 | Byte-lane enables |
| busWdata | output | 32 | Lane-steered write data |
| busAck | input | 1 | Target acknowledge, ends the current cycle |
| busClaimed | input | 1 | A target responded to this cycle |
| busRdata | input | 32 | Read lanes from the target |
| dbgValid | output | 1 | Debug character strobe |
| dbgChar | output | 8 | Debug character |

## Verification
The bench builds the block with its defaults: a 16-bit address and the debug port at 16'hFFFF. The wide address lets the table place claimed data in a small region at the bottom of the map and unclaimed cycles far above it. One two-byte read crosses the boundary between them, so a single access merges a claimed lane with an all-ones lane. Because the debug port sits at the top of the I/O space, a byte write there, a memory write to the same address, a read of it and a word write beside it all come within reach.

// File: rtl/uas_pkg.sv
package uas_pkg;

  localparam int LANES  = 4;
  localparam int DATA_W = 8 * LANES;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIRST,
    ST_SECOND,
    ST_DONE,
    ST_DEBUG
  } uas_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;   // capture the incoming request
    logic takeLo;    // capture lanes of the first cycle
    logic takeHi;    // capture lanes of the second cycle
    logic useHi;     // drive the second cycle
  } uas_strobe_t;

endpackage

// File: rtl/uas_datapath.sv
module uas_datapath
  import uas_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] DEBUG_PORT = '1
) (
  input  logic                clk,
  input  logic                rstN,
  input  uas_strobe_t         strobe,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [1:0]          reqSize,
  input  logic                reqWrite,
  input  logic                reqIo,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic                busClaimed,
  input  logic [DATA_W-1:0]   busRdata,
  output logic                reqIsDebug,
  output logic                isSplit,
  output logic [ADDR_W-1:0]   busAddr,
  output logic [LANES-1:0]    busBe,
  output logic [DATA_W-1:0]   busWdata,
  output logic [1:0]          busType,
  output logic [DATA_W-1:0]   readResult,
  output logic [7:0]          dbgChar
);

  localparam int WIDE_W = 2 * DATA_W;

  logic [ADDR_W-1:0] addrQ;
  logic [1:0]        sizeQ;
  logic              writeQ;
  logic              ioQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] loQ;
  logic [DATA_W-1:0] hiQ;

  logic [1:0]          offset;
  logic [LANES-1:0]    sizeMask;
  logic [2*LANES-1:0]  spanMask;
  logic [WIDE_W-1:0]   wideWr;
  logic [WIDE_W-1:0]   wideRd;
  logic [DATA_W-1:0]   keepMask;
  logic [ADDR_W-1:0]   baseAddr;
  logic [DATA_W-1:0]   laneIn;

  // debug diversion is decided on the incoming request
  assign reqIsDebug = reqIo && reqWrite && (reqSize == 2'd0) && (reqAddr == DEBUG_PORT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      sizeQ  <= '0;
      writeQ <= 1'b0;
      ioQ    <= 1'b0;
      wdataQ <= '0;
    end else if (strobe.loadReq) begin
      addrQ  <= reqAddr;
      sizeQ  <= reqSize;
      writeQ <= reqWrite;
      ioQ    <= reqIo;
      wdataQ <= reqWdata;
    end
  end

  assign laneIn = busClaimed ? busRdata : '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loQ <= '0;
      hiQ <= '0;
    end else begin
      if (strobe.takeLo) loQ <= laneIn;
      if (strobe.takeHi) hiQ <= laneIn;
    end
  end

  assign offset = addrQ[1:0];

  always_comb begin
    case (sizeQ)
      2'd0:    begin sizeMask = 4'b0001; keepMask = DATA_W'(32'h0000_00FF); end
      2'd1:    begin sizeMask = 4'b0011; keepMask = DATA_W'(32'h0000_FFFF); end
      default: begin sizeMask = 4'b1111; keepMask = '1; end
    endcase
  end

  assign spanMask = {{LANES{1'b0}}, sizeMask} << offset;
  assign isSplit  = |spanMask[2*LANES-1:LANES];

  assign baseAddr = {addrQ[ADDR_W-1:2], 2'b00};
  assign wideWr   = {{DATA_W{1'b0}}, wdataQ} << {offset, 3'b000};
  assign wideRd   = {hiQ, loQ} >> {offset, 3'b000};

  assign busAddr    = strobe.useHi ? baseAddr + ADDR_W'(LANES) : baseAddr;
  assign busBe      = strobe.useHi ? spanMask[2*LANES-1:LANES] : spanMask[LANES-1:0];
  assign busWdata   = strobe.useHi ? wideWr[WIDE_W-1:DATA_W] : wideWr[DATA_W-1:0];
  assign busType    = {~ioQ, writeQ};
  assign readResult = wideRd[DATA_W-1:0] & keepMask;
  assign dbgChar    = wdataQ[7:0];

  // R2: enables of an issued cycle never extend past the access size
  a_r2_be_in_span: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadReq == 1'b0 && busBe != '0) |-> ($countones(busBe) <= $countones(sizeMask)));

endmodule

// File: rtl/uas_ctrl.sv
module uas_ctrl
  import uas_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqIsDebug,
  input  logic        isSplit,
  input  logic        busAck,
  output logic        reqReady,
  output logic        busValid,
  output logic        doneValid,
  output logic        dbgValid,
  output uas_strobe_t strobe
);

  uas_state_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    reqReady  = 1'b0;
    busValid  = 1'b0;
    doneValid = 1'b0;
    dbgValid  = 1'b0;
    case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.loadReq = 1'b1;
          stateNext = reqIsDebug ? ST_DEBUG : ST_FIRST;
        end
      end
      ST_FIRST: begin
        busValid = 1'b1;
        if (busAck) begin
          strobe.takeLo = 1'b1;
          stateNext = isSplit ? ST_SECOND : ST_DONE;
        end
      end
      ST_SECOND: begin
        busValid     = 1'b1;
        strobe.useHi = 1'b1;
        if (busAck) begin
          strobe.takeHi = 1'b1;
          stateNext = ST_DONE;
        end
      end
      ST_DONE: begin
        doneValid = 1'b1;
        stateNext = ST_IDLE;
      end
      ST_DEBUG: begin
        doneValid = 1'b1;
        dbgValid  = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R1: no request is taken while a bus cycle is open
  a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> !reqReady);

endmodule

// File: rtl/unaligned_access_splitter.sv
module unaligned_access_splitter
  import uas_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] DEBUG_PORT = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic              reqIo,
  input  logic [31:0]       reqWdata,
  output logic              doneValid,
  output logic [31:0]       doneRdata,
  output logic              busValid,
  output logic [1:0]        busType,
  output logic [ADDR_W-1:0] busAddr,
  output logic [3:0]        busBe,
  output logic [31:0]       busWdata,
  input  logic              busAck,
  input  logic              busClaimed,
  input  logic [31:0]       busRdata,
  output logic              dbgValid,
  output logic [7:0]        dbgChar
);

  uas_strobe_t strobe;
  logic        reqIsDebug;
  logic        isSplit;

  uas_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqIsDebug (reqIsDebug),
    .isSplit    (isSplit),
    .busAck     (busAck),
    .reqReady   (reqReady),
    .busValid   (busValid),
    .doneValid  (doneValid),
    .dbgValid   (dbgValid),
    .strobe     (strobe)
  );

  uas_datapath #(
    .ADDR_W     (ADDR_W),
    .DEBUG_PORT (DEBUG_PORT)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqAddr    (reqAddr),
    .reqSize    (reqSize),
    .reqWrite   (reqWrite),
    .reqIo      (reqIo),
    .reqWdata   (reqWdata),
    .busClaimed (busClaimed),
    .busRdata   (busRdata),
    .reqIsDebug (reqIsDebug),
    .isSplit    (isSplit),
    .busAddr    (busAddr),
    .busBe      (busBe),
    .busWdata   (busWdata),
    .busType    (busType),
    .readResult (doneRdata),
    .dbgChar    (dbgChar)
  );

  // R8: an open cycle holds everything until acknowledged
  a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busAck) |=> (busValid && $stable(busAddr) && $stable(busBe)
                               && $stable(busWdata) && $stable(busType)));

  // R2: bus addresses are dword aligned and a cycle enables some lane
  a_r2_aligned: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> (busAddr[1:0] == 2'b00 && busBe != 4'b0000));

  // R10: the debug strobe follows acceptance directly, with no bus cycle
  a_r10_debug_direct: assert property (@(posedge clk) disable iff (!rstN)
    dbgValid |-> ($past(reqValid && reqReady) && !busValid && doneValid));

endmodule

// File: tb/unaligned_access_splitter_bench.sv
`timescale 1ns/1ps
module unaligned_access_splitter_bench;

  localparam int ADDR_W = 16;
  localparam int NV = 30;

  // {io, write, size[1:0], addr[15:0]}
  localparam logic [19:0] VEC [0:NV-1] = '{
    {1'b0,1'b1,2'd0,16'h0020}, {1'b0,1'b1,2'd0,16'h0021},
    {1'b0,1'b1,2'd0,16'h0022}, {1'b0,1'b1,2'd0,16'h0023},
    {1'b0,1'b1,2'd1,16'h0024}, {1'b0,1'b1,2'd1,16'h0025},
    {1'b0,1'b1,2'd1,16'h0026}, {1'b0,1'b1,2'd1,16'h0027},
    {1'b0,1'b1,2'd2,16'h0028}, {1'b0,1'b1,2'd2,16'h002D},
    {1'b0,1'b1,2'd2,16'h0032}, {1'b0,1'b1,2'd2,16'h0037},
    {1'b0,1'b0,2'd0,16'h0020}, {1'b0,1'b0,2'd0,16'h0023},
    {1'b0,1'b0,2'd1,16'h0025}, {1'b0,1'b0,2'd1,16'h0027},
    {1'b0,1'b0,2'd1,16'h0026}, {1'b0,1'b0,2'd2,16'h0028},
    {1'b0,1'b0,2'd2,16'h002D}, {1'b0,1'b0,2'd2,16'h0032},
    {1'b0,1'b0,2'd2,16'h0037}, {1'b0,1'b0,2'd2,16'h0021},
    {1'b0,1'b0,2'd1,16'h003F}, {1'b0,1'b0,2'd2,16'h0101},
    {1'b0,1'b0,2'd1,16'h0203}, {1'b1,1'b1,2'd0,16'h0030},
    {1'b1,1'b0,2'd2,16'h0030}, {1'b0,1'b1,2'd2,16'h003D},
    {1'b0,1'b0,2'd2,16'h003C}, {1'b0,1'b0,2'd3,16'h0029}
  };

  logic              clk = 1'b0;
  logic              rstN;
  logic              reqValid;
  logic              reqReady;
  logic [ADDR_W-1:0] reqAddr;
  logic [1:0]        reqSize;
  logic              reqWrite;
  logic              reqIo;
  logic [31:0]       reqWdata;
  logic              doneValid;
  logic [31:0]       doneRdata;
  logic              busValid;
  logic [1:0]        busType;
  logic [ADDR_W-1:0] busAddr;
  logic [3:0]        busBe;
  logic [31:0]       busWdata;
  logic              busAck;
  logic              busClaimed;
  logic [31:0]       busRdata;
  logic              dbgValid;
  logic [7:0]        dbgChar;

  always #2 clk = ~clk;

  unaligned_access_splitter #(.ADDR_W(ADDR_W)) u_unaligned_access_splitter (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWrite(reqWrite), .reqIo(reqIo),
    .reqWdata(reqWdata), .doneValid(doneValid), .doneRdata(doneRdata),
    .busValid(busValid), .busType(busType), .busAddr(busAddr), .busBe(busBe),
    .busWdata(busWdata), .busAck(busAck), .busClaimed(busClaimed),
    .busRdata(busRdata), .dbgValid(dbgValid), .dbgChar(dbgChar)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  logic [7:0] mem    [0:63];
  logic [7:0] shadow [0:63];

  // target bookkeeping
  int          cycCount;
  int          ackDelay = 0;
  int          waitCnt = 0;
  int          typeErr;
  int          stableErr;
  logic [1:0]  expType;
  logic [15:0] cycAddr [0:1];
  logic [3:0]  cycBe   [0:1];
  logic [15:0] seenAddr;
  logic [3:0]  seenBe;
  logic [31:0] seenData;

  // driver bookkeeping
  int          dbgCount;
  int          busyErr;
  logic [7:0]  dbgByte;
  logic        doneAgain;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int byteCount(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] expRead(input logic [15:0] a, input logic [1:0] sz);
    logic [31:0] r;
    logic [15:0] b;
    r = '0;
    for (int k = 0; k < byteCount(sz); k++) begin
      b = a + 16'(k);
      r[8*k +: 8] = (b < 16'h0040) ? shadow[b[5:0]] : 8'hFF;
    end
    return r;
  endfunction

  // bus target: stores enabled lanes below 0x40, leaves the rest unclaimed
  initial begin
    logic claimed;
    busAck = 1'b0; busClaimed = 1'b0; busRdata = '0;
    forever begin
      @(negedge clk);
      if (busAck) begin
        busAck = 1'b0;
      end else if (busValid) begin
        if (waitCnt == 0) begin
          seenAddr = busAddr; seenBe = busBe; seenData = busWdata;
        end else if (busAddr !== seenAddr || busBe !== seenBe || busWdata !== seenData) begin
          stableErr++;
        end
        if (waitCnt < ackDelay) begin
          waitCnt++;
        end else begin
          waitCnt = 0;
          ackDelay = (ackDelay + 1) % 3;
          if (cycCount < 2) begin
            cycAddr[cycCount] = busAddr;
            cycBe[cycCount]   = busBe;
          end
          cycCount++;
          if (busType !== expType) typeErr++;
          claimed = (busAddr < 16'h0040);
          busClaimed = claimed;
          busRdata = 32'h5AC3_3CA5;
          if (claimed) begin
            for (int k = 0; k < 4; k++) begin
              busRdata[8*k +: 8] = mem[busAddr[5:0] + 6'(k)];
              if (busType[0] && busBe[k]) mem[busAddr[5:0] + 6'(k)] = busWdata[8*k +: 8];
            end
          end
          busAck = 1'b1;
        end
      end
    end
  end

  task automatic runAccess(input logic io, input logic wr, input logic [1:0] sz,
                           input logic [15:0] addr, input logic [31:0] data,
                           output logic [31:0] rdata);
    cycCount = 0; dbgCount = 0; busyErr = 0; typeErr = 0; stableErr = 0;
    expType = {~io, wr};
    @(negedge clk);
    reqValid = 1'b1; reqIo = io; reqWrite = wr; reqSize = sz; reqAddr = addr; reqWdata = data;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    forever begin
      if (dbgValid) begin dbgCount++; dbgByte = dbgChar; end
      if (busValid && reqReady) busyErr++;
      if (doneValid) break;
      @(negedge clk);
    end
    rdata = doneRdata;
    @(negedge clk);
    doneAgain = doneValid;
    if (dbgValid) dbgCount++;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL R9 watchdog: actual no completion expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, data, mask8;
    logic        io, wr;
    logic [1:0]  sz, off;
    logic [15:0] addr, base;
    int          n, expCyc, memErr;

    for (int i = 0; i < 64; i++) begin
      mem[i] = 8'(i * 7 + 3);
      shadow[i] = mem[i];
    end
    rstN = 1'b0; reqValid = 1'b0; reqAddr = '0; reqSize = '0;
    reqWrite = 1'b0; reqIo = 1'b0; reqWdata = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 reqReady in reset", {31'b0, reqReady}, 32'd1);
    check("R11 outputs quiet in reset", {29'b0, busValid, doneValid, dbgValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 idle after reset", {28'b0, reqReady, busValid, doneValid, dbgValid}, 32'b1000);

    // table walk
    for (int i = 0; i < NV; i++) begin
      io = VEC[i][19]; wr = VEC[i][18]; sz = VEC[i][17:16]; addr = VEC[i][15:0];
      data = 32'h9E37_79B9 * 32'(i + 1);
      n = byteCount(sz);
      off = addr[1:0];
      base = {addr[15:2], 2'b00};
      mask8 = ((32'd1 << n) - 32'd1) << off;
      expCyc = (int'(off) + n > 4) ? 2 : 1;
      runAccess(io, wr, sz, addr, data, rd);
      check($sformatf("R2/R3 cycle count vec %0d", i), cycCount, expCyc);
      check($sformatf("R2 first addr vec %0d", i), {16'b0, cycAddr[0]}, {16'b0, base});
      check($sformatf("R2 first enables vec %0d", i), {28'b0, cycBe[0]}, {28'b0, mask8[3:0]});
      if (expCyc == 2) begin
        check($sformatf("R3 second addr vec %0d", i), {16'b0, cycAddr[1]}, {16'b0, base + 16'd4});
        check($sformatf("R3 second enables vec %0d", i), {28'b0, cycBe[1]}, {28'b0, mask8[7:4]});
      end
      check($sformatf("R7 cycle type vec %0d", i), typeErr, 0);
      check($sformatf("R8 held until ack vec %0d", i), stableErr, 0);
      check($sformatf("R1 not ready while busy vec %0d", i), busyErr, 0);
      check($sformatf("R9 done single pulse vec %0d", i), {31'b0, doneAgain}, 32'd0);
      if (wr) begin
        for (int k = 0; k < n; k++) begin
          if (addr + 16'(k) < 16'h0040) shadow[6'(addr + 16'(k))] = data[8*k +: 8];
        end
      end else begin
        check($sformatf("R5/R6 read data vec %0d", i), rd, expRead(addr, sz));
      end
    end

    // R4: target memory after the writes equals byte-wise model
    memErr = 0;
    for (int i = 0; i < 64; i++) if (mem[i] !== shadow[i]) memErr++;
    check("R4 lane placement in target memory", memErr, 0);

    // R10: I/O byte write to the debug port
    runAccess(1'b1, 1'b1, 2'd0, 16'hFFFF, 32'h1234_5641, rd);
    check("R10 debug write issues no bus cycle", cycCount, 0);
    check("R10 debug strobe count", dbgCount, 1);
    check("R10 debug character", {24'b0, dbgByte}, 32'h41);
    check("R9 done single pulse after debug", {31'b0, doneAgain}, 32'd0);

    // R10: memory byte write to the same address goes to the bus
    runAccess(1'b0, 1'b1, 2'd0, 16'hFFFF, 32'h0000_0042, rd);
    check("R10 memory write at debug address uses bus", cycCount, 1);
    check("R10 memory write at debug address no strobe", dbgCount, 0);
    check("R10 memory write enables", {28'b0, cycBe[0]}, 32'h8);
    check("R7 memory write type", typeErr, 0);

    // R10: I/O read of the debug port is a normal unclaimed read
    runAccess(1'b1, 1'b0, 2'd0, 16'hFFFF, 32'h0, rd);
    check("R10 I/O read at debug address uses bus", cycCount, 1);
    check("R10 I/O read at debug address no strobe", dbgCount, 0);
    check("R6 unclaimed I/O byte read", rd, 32'h0000_00FF);

    // R10: I/O word write next to the debug port is a bus cycle
    runAccess(1'b1, 1'b1, 2'd1, 16'hFFFE, 32'h0000_4344, rd);
    check("R10 I/O word write near debug port uses bus", cycCount, 1);
    check("R10 I/O word write near debug port no strobe", dbgCount, 0);
    check("R2 I/O word write enables", {28'b0, cycBe[0]}, 32'hC);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule